// File: doc/BRIEF.md
# PLL control and lock status unit

This block is the digital side of one phase-locked loop. Software sees a small window of four 32-bit registers. The control word sets power-down, bypass, the input, feedback and output divider fields, and a band field. Those fields drive the analog loop directly. A status word reports lock and a configuration fault. A measurement word returns the output rate that the current fields produce, as a code in the same units as the reference rate parameter.

Lock comes from a lock-tracking state machine. Every control write drops lock on the same edge. The machine then re-asserts lock only after a relock count of `RELOCK_CYCLES` clocks, and only when the loop is actually running. The default of 10000 cycles is 100 microseconds at 100 MHz.

The machine has five states:
- `LK_DOWN` is the reset state, with the loop powered down.
- `LK_BYPASS` means the reference is passed straight through.
- `LK_FAULT` means the feedback field is zero while the loop should run.
- `LK_RELOCK` means the relock count is in progress.
- `LK_LOCKED` means the loop is locked.

Every control write leaves the current state and picks the new one by priority: bypass first, then power-down, then a zero feedback field, and otherwise `LK_RELOCK`. `LK_RELOCK` moves to `LK_LOCKED` when its count completes.

The rate code comes from a separate two-state machine. `RC_IDLE` holds a valid result. `RC_DIV` runs a restoring divider for one iteration per clock, and every control write starts it again.

Top module: `pll_ctl_unit`

## Requirements
- R1: After reset the control word reads 0x00000001 (powered down, every other field zero), the status word reads 0, `pll_pd` is 1, and `rate_valid` is 1 with `rate_code` equal to 0.
- R2: A write to word 0 stores the control fields at fixed positions: power-down bit 0, bypass bit 1, output divider bits 3:2, input divider bits 8:4, feedback divider bits 15:9, band bits 23:20. Each field drives its `pll_*` output, and every other bit reads back as 0.
- R3: With bypass and power-down both clear, `rate_code` and the word-2 read equal floor(REF_RATE × 2 × (fb+1) / ((idiv+1) × 2^odiv)). Here fb, idiv and odiv are the raw field values.
- R4: With bypass set, the rate code equals REF_RATE whatever the power-down bit and the divider fields hold.
- R5: With power-down set and bypass clear, the rate code is 0.
- R6: After a control write, `rate_valid` is 0 for exactly RATE_W clocks and returns to 1 on the RATE_W-th edge after the write edge.
- R7: A control write clears `pll_lock` on its own edge. For a running configuration (bypass 0, power-down 0, feedback field non-zero), lock returns exactly RELOCK_CYCLES edges after the write edge.
- R8: A control write that lands on the edge where the relock count would complete restarts the count. Lock stays 0 and rises RELOCK_CYCLES edges after that later write.
- R9: A control write whose feedback field is 0 sets `pll_err` (status bit 1). Lock then stays 0 while the loop should run. The next control write with a non-zero feedback field clears the flag.
- R10: Lock is never 1 while the loop is powered down or bypassed.
- R11: Writes to words 1, 2 and 3 are ignored: the control fields, lock, and the rate code with its valid flag are unchanged.
- R12: The status word at word 1 reports lock in bit 0 and the error flag in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_word | input | 2 | Register word index (byte offset / 4): 0 control, 1 status, 2 rate, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| pll_pd | output | 1 | Power-down to the analog loop |
| pll_bypass | output | 1 | Bypass to the analog loop |
| pll_odiv | output | 2 | Output divider field (divide by 2^field) |
| pll_idiv | output | 5 | Input divider field (divide by field+1) |
| pll_fbdiv | output | 7 | Feedback divider field (multiply by 2 × (field+1)) |
| pll_band | output | 4 | Band field |
| pll_lock | output | 1 | Loop locked |
| pll_err | output | 1 | Configuration fault flag |
| rate_code | output | RATE_W | Effective output rate code |
| rate_valid | output | 1 | Rate code holds the result for the current control word |

## Verification
The two functions that can fall on the same edge are a new control write and the completion of the relock count. The bench lets a running configuration count down and places a second control write exactly on the edge where the count would expire. The write must win: lock stays low on that edge and the following RELOCK_CYCLES-1 edges, and it rises only on the RELOCK_CYCLES-th edge after the second write. The divider restart on the same write is judged alongside, because `rate_valid` must again stay low for exactly RATE_W clocks.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

    // Control word layout; a neighbouring analog block decodes these positions
    localparam int PD_BIT   = 0;
    localparam int BYP_BIT  = 1;
    localparam int ODIV_LSB = 2;
    localparam int ODIV_W   = 2;
    localparam int IDIV_LSB = 4;
    localparam int IDIV_W   = 5;
    localparam int FB_LSB   = 9;
    localparam int FB_W     = 7;
    localparam int BAND_LSB = 20;
    localparam int BAND_W   = 4;

    localparam logic [31:0] CTRL_MASK =
        32'((1 << (FB_LSB + FB_W)) - 1) | 32'(((1 << BAND_W) - 1) << BAND_LSB);
    localparam logic [31:0] CTRL_RESET = 32'(1 << PD_BIT);

    // Register word indices inside the 16-byte window
    localparam logic [1:0] WORD_CTRL = 2'd0;
    localparam logic [1:0] WORD_STAT = 2'd1;
    localparam logic [1:0] WORD_RATE = 2'd2;
    localparam logic [1:0] WORD_RSVD = 2'd3;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic [FB_W-1:0]   fb;
        logic [IDIV_W-1:0] idiv;
        logic [ODIV_W-1:0] odiv;
        logic              bypass;
        logic              pd;
    } pll_cfg_t;

    typedef enum logic [2:0] {
        LK_DOWN,
        LK_BYPASS,
        LK_FAULT,
        LK_RELOCK,
        LK_LOCKED
    } lock_state_e;

    typedef enum logic {
        RC_IDLE,
        RC_DIV
    } rate_state_e;

endpackage

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    input  logic              lock,
    input  logic [RATE_W-1:0] rate_code,
    output logic [31:0]       bus_rdata,
    output logic              ctrl_wr,
    output logic              wr_pd,
    output logic              wr_bypass,
    output logic [ODIV_W-1:0] wr_odiv,
    output logic [IDIV_W-1:0] wr_idiv,
    output logic [FB_W-1:0]   wr_fb,
    output pll_cfg_t          cfg,
    output logic              err
);

    logic [31:0] ctrl_q;
    logic        err_q;

    assign ctrl_wr   = bus_wr && (bus_word == WORD_CTRL);

    // Fields of the word being written, seen by the state machines on the write edge
    assign wr_pd     = bus_wdata[PD_BIT];
    assign wr_bypass = bus_wdata[BYP_BIT];
    assign wr_odiv   = bus_wdata[ODIV_LSB +: ODIV_W];
    assign wr_idiv   = bus_wdata[IDIV_LSB +: IDIV_W];
    assign wr_fb     = bus_wdata[FB_LSB +: FB_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            err_q  <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
            err_q  <= (wr_fb == '0);
        end
    end

    always_comb begin
        cfg.pd     = ctrl_q[PD_BIT];
        cfg.bypass = ctrl_q[BYP_BIT];
        cfg.odiv   = ctrl_q[ODIV_LSB +: ODIV_W];
        cfg.idiv   = ctrl_q[IDIV_LSB +: IDIV_W];
        cfg.fb     = ctrl_q[FB_LSB +: FB_W];
        cfg.band   = ctrl_q[BAND_LSB +: BAND_W];
    end

    assign err = err_q;

    always_comb begin
        unique case (bus_word)
            WORD_CTRL: bus_rdata = ctrl_q;
            WORD_STAT: bus_rdata = {30'd0, err_q, lock};
            WORD_RATE: bus_rdata = 32'(rate_code);
            WORD_RSVD: bus_rdata = 32'd0;
            default:   bus_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_ctl_pkg::*;
#(
    parameter int RELOCK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_bypass,
    input  logic wr_pd,
    input  logic wr_fb_zero,
    output logic lock
);

    localparam int CNT_W = (RELOCK_CYCLES > 1) ? $clog2(RELOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELOCK_CYCLES - 1);

    lock_state_e       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;

    // Next state: a control write always wins over the relock count
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            if (wr_bypass)       st_d = LK_BYPASS;
            else if (wr_pd)      st_d = LK_DOWN;
            else if (wr_fb_zero) st_d = LK_FAULT;
            else                 st_d = LK_RELOCK;
        end else begin
            unique case (st_q)
                LK_RELOCK: if (cnt_q == CNT_LAST) st_d = LK_LOCKED;
                LK_DOWN,
                LK_BYPASS,
                LK_FAULT,
                LK_LOCKED: st_d = st_q;
                default:   st_d = LK_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_DOWN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (ctrl_wr || st_q != LK_RELOCK)  cnt_q <= '0;
        else                                    cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        lock = (st_q == LK_LOCKED);
    end

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_ctl_pkg::*;
#(
    parameter int REF_RATE = 33333,
    parameter int RATE_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_pd,
    input  logic              cfg_bypass,
    input  logic [ODIV_W-1:0] cfg_odiv,
    input  logic [IDIV_W-1:0] cfg_idiv,
    input  logic [FB_W-1:0]   cfg_fb,
    output logic [RATE_W-1:0] rate_code,
    output logic              rate_valid
);

    localparam int NUM_W = RATE_W;
    localparam int DEN_W = IDIV_W + 1;
    localparam int ITR_W = $clog2(NUM_W);
    localparam logic [ITR_W-1:0] ITR_LAST = ITR_W'(NUM_W - 1);

    rate_state_e        st_q, st_d;
    logic [ITR_W-1:0]   itr_q;
    logic [NUM_W-1:0]   quo_q;
    logic [DEN_W-1:0]   rem_q;
    logic [DEN_W-1:0]   den_q;
    logic [ODIV_W-1:0]  odiv_q;
    logic               byp_q;
    logic               pd_q;

    logic [NUM_W-1:0]   num_start;
    logic [DEN_W-1:0]   den_start;
    logic [DEN_W:0]     rem_sh;
    logic               take;

    assign num_start = NUM_W'(REF_RATE) * ((NUM_W'(cfg_fb) + NUM_W'(1)) << 1);
    assign den_start = DEN_W'(cfg_idiv) + DEN_W'(1);

    // One restoring-division step per clock
    assign rem_sh = {rem_q, quo_q[NUM_W-1]};
    assign take   = (rem_sh >= {1'b0, den_q});

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d = RC_DIV;
        end else begin
            unique case (st_q)
                RC_IDLE: st_d = RC_IDLE;
                RC_DIV:  if (itr_q == ITR_LAST) st_d = RC_IDLE;
                default: st_d = RC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itr_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= DEN_W'(1);
            odiv_q <= '0;
            byp_q  <= 1'b0;
            pd_q   <= 1'b1;
        end else if (start) begin
            itr_q  <= '0;
            quo_q  <= num_start;
            rem_q  <= '0;
            den_q  <= den_start;
            odiv_q <= cfg_odiv;
            byp_q  <= cfg_bypass;
            pd_q   <= cfg_pd;
        end else if (st_q == RC_DIV) begin
            itr_q  <= itr_q + ITR_W'(1);
            quo_q  <= {quo_q[NUM_W-2:0], take};
            rem_q  <= take ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        end
    end

    always_comb begin
        if (byp_q)     rate_code = RATE_W'(REF_RATE);
        else if (pd_q) rate_code = '0;
        else           rate_code = quo_q >> odiv_q;
        rate_valid = (st_q == RC_IDLE);
    end

endmodule

// File: rtl/pll_ctl_unit.sv
module pll_ctl_unit
    import pll_ctl_pkg::*;
#(
    parameter int REF_RATE      = 33333,
    parameter int REF_W         = 16,
    parameter int RELOCK_CYCLES = 10000,
    parameter int RATE_W        = REF_W + FB_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pll_pd,
    output logic              pll_bypass,
    output logic [ODIV_W-1:0] pll_odiv,
    output logic [IDIV_W-1:0] pll_idiv,
    output logic [FB_W-1:0]   pll_fbdiv,
    output logic [BAND_W-1:0] pll_band,
    output logic              pll_lock,
    output logic              pll_err,
    output logic [RATE_W-1:0] rate_code,
    output logic              rate_valid
);

    logic              ctrl_wr;
    logic              wr_pd;
    logic              wr_bypass;
    logic [ODIV_W-1:0] wr_odiv;
    logic [IDIV_W-1:0] wr_idiv;
    logic [FB_W-1:0]   wr_fb;
    pll_cfg_t          cfg;
    logic              lock;
    logic              err;

    pll_ctl_regs #(.RATE_W(RATE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .lock      (lock),
        .rate_code (rate_code),
        .bus_rdata (bus_rdata),
        .ctrl_wr   (ctrl_wr),
        .wr_pd     (wr_pd),
        .wr_bypass (wr_bypass),
        .wr_odiv   (wr_odiv),
        .wr_idiv   (wr_idiv),
        .wr_fb     (wr_fb),
        .cfg       (cfg),
        .err       (err)
    );

    pll_lock_fsm #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_bypass  (wr_bypass),
        .wr_pd      (wr_pd),
        .wr_fb_zero (wr_fb == '0),
        .lock       (lock)
    );

    pll_rate_calc #(.REF_RATE(REF_RATE), .RATE_W(RATE_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ctrl_wr),
        .cfg_pd     (wr_pd),
        .cfg_bypass (wr_bypass),
        .cfg_odiv   (wr_odiv),
        .cfg_idiv   (wr_idiv),
        .cfg_fb     (wr_fb),
        .rate_code  (rate_code),
        .rate_valid (rate_valid)
    );

    assign pll_pd     = cfg.pd;
    assign pll_bypass = cfg.bypass;
    assign pll_odiv   = cfg.odiv;
    assign pll_idiv   = cfg.idiv;
    assign pll_fbdiv  = cfg.fb;
    assign pll_band   = cfg.band;
    assign pll_lock   = lock;
    assign pll_err    = err;

endmodule

// File: rtl/pll_ctl_unit_chk.sv
module pll_ctl_unit_chk
    import pll_ctl_pkg::*;
#(
    parameter int REF_RATE      = 33333,
    parameter int RELOCK_CYCLES = 10000,
    parameter int RATE_W        = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_word,
    input logic [FB_W-1:0]   wr_fb,
    input logic              pll_pd,
    input logic              pll_bypass,
    input logic [ODIV_W-1:0] pll_odiv,
    input logic [IDIV_W-1:0] pll_idiv,
    input logic [FB_W-1:0]   pll_fbdiv,
    input logic [BAND_W-1:0] pll_band,
    input logic              pll_lock,
    input logic              pll_err,
    input logic [RATE_W-1:0] rate_code,
    input logic              rate_valid
);

    logic        ctrl_hit;
    logic [31:0] since_wr;

    assign ctrl_hit = bus_wr && (bus_word == WORD_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_wr <= '0;
        else if (ctrl_hit)         since_wr <= '0;
        else if (since_wr != '1)   since_wr <= since_wr + 32'd1;
    end

    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> !pll_lock);

    // R7
    relock_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_lock) |-> (since_wr == 32'(RELOCK_CYCLES)));

    // R6
    rate_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> !rate_valid);

    // R10
    lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_lock |-> (!pll_pd && !pll_bypass));

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && wr_fb == '0) |=> (pll_err && !pll_lock));

    // R4
    bypass_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && pll_bypass) |-> (rate_code == RATE_W'(REF_RATE)));

    // R5
    down_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && pll_pd && !pll_bypass) |-> (rate_code == '0));

    // R11
    side_write_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ctrl_hit) |=>
            $stable({pll_pd, pll_bypass, pll_odiv, pll_idiv, pll_fbdiv, pll_band}));

    // R11
    side_write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ctrl_hit && pll_lock) |=> pll_lock);

endmodule

bind pll_ctl_unit pll_ctl_unit_chk #(
    .REF_RATE      (REF_RATE),
    .RELOCK_CYCLES (RELOCK_CYCLES),
    .RATE_W        (RATE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_word   (bus_word),
    .wr_fb      (bus_wdata[pll_ctl_pkg::FB_LSB +: pll_ctl_pkg::FB_W]),
    .pll_pd     (pll_pd),
    .pll_bypass (pll_bypass),
    .pll_odiv   (pll_odiv),
    .pll_idiv   (pll_idiv),
    .pll_fbdiv  (pll_fbdiv),
    .pll_band   (pll_band),
    .pll_lock   (pll_lock),
    .pll_err    (pll_err),
    .rate_code  (rate_code),
    .rate_valid (rate_valid)
);

// File: tb/pll_ctl_unit_bench.sv
module pll_ctl_unit_bench;

    localparam int REF    = 33333;
    localparam int RELOCK = 8;
    localparam int NUM_W  = 16 + 7 + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_word = 2'd0;
    logic [31:0]      bus_wdata = 32'd0;
    logic [31:0]      bus_rdata;
    logic             pll_pd, pll_bypass, pll_lock, pll_err, rate_valid;
    logic [1:0]       pll_odiv;
    logic [4:0]       pll_idiv;
    logic [6:0]       pll_fbdiv;
    logic [3:0]       pll_band;
    logic [NUM_W-1:0] rate_code;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pll_ctl_unit #(
        .REF_RATE      (REF),
        .REF_W         (16),
        .RELOCK_CYCLES (RELOCK)
    ) u_pll_ctl_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_word   (bus_word),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_pd     (pll_pd),
        .pll_bypass (pll_bypass),
        .pll_odiv   (pll_odiv),
        .pll_idiv   (pll_idiv),
        .pll_fbdiv  (pll_fbdiv),
        .pll_band   (pll_band),
        .pll_lock   (pll_lock),
        .pll_err    (pll_err),
        .rate_code  (rate_code),
        .rate_valid (rate_valid)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge; the write is taken on the next rising edge
    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_word = w;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input int pd, input int byp, input int od,
                                       input int id, input int fb, input int band);
        return 32'((band << 20) | (fb << 9) | (id << 4) | (od << 2) | (byp << 1) | pd);
    endfunction

    function automatic longint exp_rate(input int od, input int id, input int fb);
        return (longint'(REF) * 2 * (fb + 1)) / ((id + 1) * (1 << od));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int fbs [7] = '{1, 7, 23, 47, 63, 100, 127};

        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(2'd0, d); check("R1", "ctrl word", d, 32'h1);
        rd(2'd1, d); check("R1", "status word", d, 0);
        check("R1", "pll_pd", pll_pd, 1);
        check("R1", "rate_valid", rate_valid, 1);
        check("R1", "rate_code", rate_code, 0);

        // R2 all ones: only defined fields stick; R4 bypass with power-down
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R2", "masked readback", d, 32'h00F0_FFFF);
        check("R2", "pll_band", pll_band, 15);
        check("R2", "pll_fbdiv", pll_fbdiv, 127);
        check("R10", "lock in bypass", pll_lock, 0);
        step(NUM_W);
        check("R4", "bypass rate", rate_code, REF);
        check("R10", "lock after bypass wait", pll_lock, 0);

        // R2 mixed pattern, fields extracted by position
        d = 32'h00A0_5A5C;
        wr(2'd0, d);
        check("R2", "pd", pll_pd, d[0]);
        check("R2", "bypass", pll_bypass, d[1]);
        check("R2", "odiv", pll_odiv, (d >> 2) & 3);
        check("R2", "idiv", pll_idiv, (d >> 4) & 31);
        check("R2", "fbdiv", pll_fbdiv, (d >> 9) & 127);
        check("R2", "band", pll_band, (d >> 20) & 15);
        step(NUM_W);

        // R3 / R6 sweep over every input and output divider with a feedback spread
        for (int id = 0; id < 32; id++) begin
            for (int od = 0; od < 4; od++) begin
                for (int f = 0; f < 7; f++) begin
                    wr(2'd0, cw(0, 0, od, id, fbs[f], 0));
                    step(NUM_W - 1);
                    check("R6", "valid still low", rate_valid, 0);
                    step(1);
                    check("R6", "valid high", rate_valid, 1);
                    check("R3", "rate_code", rate_code, exp_rate(od, id, fbs[f]));
                    rd(2'd2, d);
                    check("R3", "rate word", d, exp_rate(od, id, fbs[f]));
                    check("R7", "locked after relock", pll_lock, 1);
                end
            end
        end

        // R7 exact relock timing, starting from locked
        wr(2'd0, cw(0, 0, 1, 3, 20, 2));
        check("R7", "lock dropped on write", pll_lock, 0);
        step(RELOCK - 1);
        check("R7", "lock low one edge early", pll_lock, 0);
        step(1);
        check("R7", "lock high on time", pll_lock, 1);
        rd(2'd1, d); check("R12", "status locked", d, 1);

        // R8 second write on the relock completion edge
        wr(2'd0, cw(0, 0, 0, 1, 30, 0));
        step(RELOCK - 1);
        check("R8", "lock low before collision", pll_lock, 0);
        wr(2'd0, cw(0, 0, 2, 4, 50, 1));
        check("R8", "lock held low at collision", pll_lock, 0);
        check("R8", "rate restarted", rate_valid, 0);
        step(RELOCK - 1);
        check("R8", "lock low before new expiry", pll_lock, 0);
        step(1);
        check("R8", "lock after restarted count", pll_lock, 1);
        step(NUM_W);
        check("R8", "rate after restart", rate_code, exp_rate(2, 4, 50));

        // R9 zero feedback field
        wr(2'd0, cw(0, 0, 1, 2, 0, 3));
        check("R9", "err set", pll_err, 1);
        rd(2'd1, d); check("R12", "status fault", d, 2);
        step(NUM_W + RELOCK);
        check("R9", "lock stays low", pll_lock, 0);
        check("R3", "rate with zero fb", rate_code, exp_rate(1, 2, 0));
        wr(2'd0, cw(0, 0, 0, 0, 5, 0));
        check("R9", "err cleared", pll_err, 0);
        step(RELOCK);
        check("R9", "lock after clearing", pll_lock, 1);

        // R5 powered down
        wr(2'd0, cw(1, 0, 2, 3, 9, 0));
        step(NUM_W + RELOCK);
        check("R5", "power-down rate", rate_code, 0);
        check("R10", "lock when powered down", pll_lock, 0);

        // R11 writes to the other words
        wr(2'd0, cw(0, 0, 3, 7, 11, 5));
        step(NUM_W);
        for (int w = 1; w < 4; w++) begin
            wr(2'(w), 32'hFFFF_FFFF);
            check("R11", "lock kept", pll_lock, 1);
            check("R11", "valid kept", rate_valid, 1);
            check("R11", "rate kept", rate_code, exp_rate(3, 7, 11));
            rd(2'd0, d); check("R11", "ctrl kept", d, cw(0, 0, 3, 7, 11, 5));
        end
        step(RELOCK + 2);
        check("R11", "lock after side writes", pll_lock, 1);
        rd(2'd3, d); check("R11", "reserved word", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule